// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request, given as a byte address and a byte length, into a series of four-byte erase commands. It sends them through a byte-level SPI master to a serial flash that is organised in pages. It first divides the address and the length by the runtime page size. If either division leaves a remainder, the request is refused. Otherwise the block works in page units. At each step it erases either one page or a whole aligned group of eight pages, whichever the alignment and the remaining length allow.

After every erase command the block reads the device status. It keeps reading until the ready bit comes back set, waiting a programmable number of timebase ticks between reads that report busy. A transfer error on an erase command makes the block repeat the same step once the device is ready. When no pages remain, it pulses `done_o`. The SPI shifter and the tick source sit outside the block.

Top module: `flash_erase_seq`

## Requirements
- R1: If `page_size_i` is zero, or `addr_i` or `len_i` is not a whole multiple of `page_size_i`, the request ends with `done_o` and `err_o` high in the same cycle, and no SPI byte is started.
- R2: A step uses opcode 0x50 (eight-page erase) when the current page number is a multiple of 8 and at least 8 pages remain. Every other step uses opcode 0x81 (single-page erase).
- R3: An erase command is four bytes, in this order: the opcode, bits 23:16 of the flash address, bits 15:8 of the flash address, then 0x00. The flash address is the page number shifted left by `page_shift_i`.
- R4: `spi_hold_o` is 1 on the first three bytes of an erase command and 0 on its fourth byte. A status read is two bytes: 0xD7 with hold 1, then 0x00 with hold 0. The status comes back in `spi_rx_i` on the second byte.
- R5: After each erase command the block repeats the status read until bit 7 of the status byte is 1. It starts no other command before that.
- R6: After a successful eight-page erase, the page number advances by 8 and the remaining count drops by 8. After a successful single-page erase, both change by 1.
- R7: If `spi_err_i` is high on any `spi_done_i` of an erase command, the block sends the same command again once the device is ready, without advancing.
- R8: After a status byte with bit 7 clear, the next status read starts only after exactly `poll_gap_i` cycles with `tick_i` high. When `poll_gap_i` is 0 it starts without waiting.
- R9: `done_o` is a one-cycle pulse, raised after the last ready status. A zero-length request completes with `done_o` and without `err_o`, and starts no SPI byte.
- R10: `req_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an erase request (taken when idle) |
| addr_i | input | ADDR_W | Byte address of the erase |
| len_i | input | ADDR_W | Byte length of the erase |
| page_size_i | input | PS_W | Page size in bytes |
| page_shift_i | input | SH_W | Left shift that packs the page number into the flash address |
| poll_gap_i | input | GAP_W | Ticks to wait between busy status reads |
| tick_i | input | 1 | Timebase tick |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request refused (valid with done_o) |
| spi_start_o | output | 1 | Start one SPI byte transfer |
| spi_tx_o | output | 8 | Byte to send |
| spi_hold_o | output | 1 | Keep chip select asserted after this byte |
| spi_done_i | input | 1 | Byte transfer finished |
| spi_rx_i | input | 8 | Byte received (valid with spi_done_i) |
| spi_err_i | input | 1 | Transfer error (valid with spi_done_i) |

## Verification
A behavioural flash model answers every byte and holds the device busy for a set number of status reads. A reference built from page arithmetic predicts the exact list of erase commands. The test requests are chosen to separate distinct behaviours:
- An aligned 16-page run shows that two eight-page erases are chosen.
- A run that starts at page 3 with a 264-byte page and a shift of 9 checks the single-page choice and the packing of addresses that are not a power of two.
- A run that is aligned but 7 pages short rules out the eight-page erase.
- A high address checks the upper address byte.
- Misaligned requests and a zero-length request separate refusal from empty completion.
- An injected transfer error expects the same command twice.
- A second request raised mid-run must leave the command list unchanged.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam int         READY_BIT      = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_DIV, S_CMD, S_CMD_W, S_POLL, S_POLL_W, S_GAP
  } fes_state_e;
endpackage

// File: rtl/fes_serial_div.sv
module fes_serial_div #(
  parameter int W  = 24,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [W-1:0]  quot_o,
  output logic [DW-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_q;
  logic [DW-1:0] r_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  always_comb begin
    trial = {r_q, q_q[W-1]};
    ge    = trial >= {1'b0, divisor_i};
    diff  = trial - {1'b0, divisor_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q   <= dividend_i;
        r_q   <= '0;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        q_q    <= {q_q[W-2:0], ge};
        r_q    <= ge ? diff[DW-1:0] : trial[DW-1:0];
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
  assign rem_o  = r_q;

  // remainder must fall below a nonzero divisor
  p_rem_below_divisor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && divisor_i != '0) |-> (rem_o < divisor_i));
endmodule

// File: rtl/fes_step_pick.sv
module fes_step_pick
  import fes_pkg::*;
#(
  parameter int PW       = 24,
  parameter int SH_W     = 5,
  parameter int BLK_LOG2 = 3
) (
  input  logic [PW-1:0]   page_i,
  input  logic [PW-1:0]   left_i,
  input  logic [SH_W-1:0] shift_i,
  output logic [7:0]      op_o,
  output logic [7:0]      addr_hi_o,
  output logic [7:0]      addr_mid_o,
  output logic [PW-1:0]   step_o
);
  localparam int BLK_PAGES = 1 << BLK_LOG2;

  logic        use_blk;
  logic [31:0] flash_addr;

  generate
    if (BLK_LOG2 == 0) begin : g_page_only
      assign use_blk = 1'b0;
    end else begin : g_blk
      assign use_blk = (page_i[BLK_LOG2-1:0] == '0) && (left_i >= PW'(BLK_PAGES));
    end
  endgenerate

  always_comb begin
    flash_addr = 32'(page_i) << shift_i;
    op_o       = use_blk ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
    addr_hi_o  = flash_addr[23:16];
    addr_mid_o = flash_addr[15:8];
    step_o     = use_blk ? PW'(BLK_PAGES) : PW'(1);
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PS_W     = 12,
  parameter int SH_W     = 5,
  parameter int GAP_W    = 8,
  parameter int BLK_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [PS_W-1:0]   page_size_i,
  input  logic [SH_W-1:0]   page_shift_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              spi_start_o,
  output logic [7:0]        spi_tx_o,
  output logic              spi_hold_o,
  input  logic              spi_done_i,
  input  logic [7:0]        spi_rx_i,
  input  logic              spi_err_i
);
  localparam int BLK_PAGES = 1 << BLK_LOG2;

  fes_state_e        state_q;
  logic [1:0]        idx_q;
  logic [ADDR_W-1:0] cur_page_q, left_q;
  logic              xerr_q, done_q, err_q;
  logic [GAP_W-1:0]  gap_q;

  logic              div_go, da_done, dl_done;
  logic [ADDR_W-1:0] qa, ql;
  logic [PS_W-1:0]   ra, rl;
  logic [7:0]        op, a_hi, a_mid;
  logic [ADDR_W-1:0] step;

  assign div_go = (state_q == S_IDLE) && req_i;

  fes_serial_div #(.W(ADDR_W), .DW(PS_W)) u_div_addr (
    .clk_i, .rst_ni, .start_i(div_go), .dividend_i(addr_i), .divisor_i(page_size_i),
    .done_o(da_done), .quot_o(qa), .rem_o(ra));

  fes_serial_div #(.W(ADDR_W), .DW(PS_W)) u_div_len (
    .clk_i, .rst_ni, .start_i(div_go), .dividend_i(len_i), .divisor_i(page_size_i),
    .done_o(dl_done), .quot_o(ql), .rem_o(rl));

  fes_step_pick #(.PW(ADDR_W), .SH_W(SH_W), .BLK_LOG2(BLK_LOG2)) u_pick (
    .page_i(cur_page_q), .left_i(left_q), .shift_i(page_shift_i),
    .op_o(op), .addr_hi_o(a_hi), .addr_mid_o(a_mid), .step_o(step));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      cur_page_q <= '0;
      left_q     <= '0;
      xerr_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      gap_q      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_i) state_q <= S_DIV;
        S_DIV: if (da_done && dl_done) begin
          if (page_size_i == '0 || ra != '0 || rl != '0) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (ql == '0) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cur_page_q <= qa;
            left_q     <= ql;
            idx_q      <= '0;
            xerr_q     <= 1'b0;
            state_q    <= S_CMD;
          end
        end
        S_CMD:  state_q <= S_CMD_W;
        S_CMD_W: if (spi_done_i) begin
          if (spi_err_i) xerr_q <= 1'b1;
          idx_q   <= idx_q + 2'd1;
          state_q <= (idx_q == 2'd3) ? S_POLL : S_CMD;
        end
        S_POLL: state_q <= S_POLL_W;
        S_POLL_W: if (spi_done_i) begin
          if (idx_q == 2'd0) begin
            idx_q   <= 2'd1;
            state_q <= S_POLL;
          end else begin
            idx_q <= 2'd0;
            if (spi_rx_i[READY_BIT]) begin
              if (xerr_q) begin
                xerr_q  <= 1'b0;
                state_q <= S_CMD;
              end else begin
                cur_page_q <= cur_page_q + step;
                left_q     <= left_q - step;
                if (left_q == step) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
                end else begin
                  state_q <= S_CMD;
                end
              end
            end else if (poll_gap_i == '0) begin
              state_q <= S_POLL;
            end else begin
              gap_q   <= '0;
              state_q <= S_GAP;
            end
          end
        end
        S_GAP: if (tick_i) begin
          gap_q <= gap_q + 1'b1;
          if (gap_q + 1'b1 == poll_gap_i) state_q <= S_POLL;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    spi_start_o = (state_q == S_CMD) || (state_q == S_POLL);
    spi_tx_o    = 8'h00;
    spi_hold_o  = 1'b0;
    if (state_q == S_CMD) begin
      spi_hold_o = (idx_q != 2'd3);
      unique case (idx_q)
        2'd0:    spi_tx_o = op;
        2'd1:    spi_tx_o = a_hi;
        2'd2:    spi_tx_o = a_mid;
        default: spi_tx_o = 8'h00;
      endcase
    end else if (state_q == S_POLL) begin
      spi_hold_o = (idx_q == 2'd0);
      spi_tx_o   = (idx_q == 2'd0) ? OP_STATUS : 8'h00;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !spi_start_o);
  p_err_with_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_block_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD && idx_q == 2'd0 && spi_tx_o == OP_BLOCK_ERASE)
      |-> ((cur_page_q % ADDR_W'(BLK_PAGES)) == '0 && left_q >= ADDR_W'(BLK_PAGES)));
  p_advance_on_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_page_q != $past(cur_page_q) && $past(state_q) != S_DIV)
      |-> $past(state_q == S_POLL_W && spi_done_i && spi_rx_i[READY_BIT] && !xerr_q));
endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0, len = '0;
  logic [11:0] psize = 12'd256;
  logic [4:0]  pshift = 5'd8;
  logic [7:0]  gap = '0;
  logic        tick = 1'b0;
  logic        busy, done, err, s_start, s_hold;
  logic [7:0]  s_tx;
  logic        s_done = 1'b0, s_err = 1'b0;
  logic [7:0]  s_rx = '0;

  always #2 clk = ~clk;

  flash_erase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .page_size_i(psize), .page_shift_i(pshift), .poll_gap_i(gap), .tick_i(tick),
    .busy_o(busy), .done_o(done), .err_o(err), .spi_start_o(s_start),
    .spi_tx_o(s_tx), .spi_hold_o(s_hold), .spi_done_i(s_done),
    .spi_rx_i(s_rx), .spi_err_i(s_err));

  int checks = 0, fails = 0, cyc = 0;
  int busy_polls = 0, err_at = -1;

  // timebase: one tick every 4 cycles
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tick <= (cyc % 4 == 3);
  end

  // behavioural flash device
  int lat = 0, pos = 0, busy_left = 0, erase_cnt = 0;
  bit in_erase = 0, p_err = 0;
  logic [7:0] p_rx = '0;
  always @(posedge clk) begin
    s_done <= 1'b0;
    s_err  <= 1'b0;
    if (lat == 1) begin
      s_done <= 1'b1; s_rx <= p_rx; s_err <= p_err;
    end
    if (lat > 0) lat <= lat - 1;
    if (s_start) begin
      bit e;
      e = (pos == 0) ? (s_tx != 8'hD7) : in_erase;
      in_erase <= e;
      lat <= 2;
      p_rx <= 8'h00;
      p_err <= e && pos == 3 && erase_cnt == err_at;
      if (!e && pos == 1) begin
        if (busy_left > 0) begin p_rx <= 8'h01; busy_left <= busy_left - 1; end
        else p_rx <= 8'h80;
      end
      if (s_hold) pos <= pos + 1;
      else begin
        pos <= 0;
        if (e) begin busy_left <= busy_polls; erase_cnt <= erase_cnt + 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // reference: expected command words {op, hi, mid}
  int exp_q[$];
  int polls = 0, erases_seen = 0, done_cnt = 0, err_seen = 0;
  int fb[4], fh[4], fn = 0;
  bit st_pend = 0, gapping = 0;
  int ticks = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (s_start && gapping) begin
        chk(ticks == gap, "R8 poll gap ticks", ticks, gap);
        gapping = 0;
      end else if (gapping && tick) ticks++;
      if (s_done && st_pend) begin
        st_pend = 0;
        if (!s_rx[7]) begin gapping = 1; ticks = 0; end
      end
      if (s_start) begin
        if (fn < 4) begin fb[fn] = s_tx; fh[fn] = s_hold; end
        fn++;
        if (!s_hold) begin
          if (fb[0] == 8'hD7) begin
            chk(fn == 2 && fh[0] == 1 && fb[1] == 0, "R4 status frame", fn, 2);
            polls++;
            st_pend = 1;
          end else begin
            int w, e;
            w = (fb[0] << 16) | (fb[1] << 8) | fb[2];
            e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            chk(fn == 4 && w == e && fb[3] == 0, "R2/R3 erase command", w, e);
            chk(fh[0] && fh[1] && fh[2], "R4 hold on command", fh[0] + fh[1] + fh[2], 3);
            if (erases_seen > 0) chk(polls == busy_polls + 1, "R5 polls per command", polls, busy_polls + 1);
            erases_seen++;
            polls = 0;
          end
          fn = 0;
        end
      end
      if (done) begin
        done_cnt++;
        err_seen = err;
      end
    end
  end

  task automatic build(input int a, input int l, input int ps, input int sh);
    int p, n, k;
    exp_q.delete();
    p = a / ps; n = l / ps; k = 0;
    while (n > 0) begin
      bit blk;
      int fa, w;
      blk = (p % 8 == 0) && n >= 8;
      fa = p << sh;
      w = ((blk ? 8'h50 : 8'h81) << 16) | (((fa >> 16) & 255) << 8) | ((fa >> 8) & 255);
      exp_q.push_back(w);
      if (k == err_at) exp_q.push_back(w);
      k++;
      p += blk ? 8 : 1;
      n -= blk ? 8 : 1;
    end
  endtask

  task automatic run(input string tag, input int a, input int l, input int ps, input int sh,
                     input int g, input int bp, input int ea, input bit exp_err, input bit dup_req);
    int t;
    @(negedge clk);
    addr = 24'(a); len = 24'(l); psize = 12'(ps); pshift = 5'(sh); gap = 8'(g);
    busy_polls = bp; err_at = ea; erase_cnt = 0;
    if (!exp_err) build(a, l, ps, sh); else exp_q.delete();
    polls = 0; erases_seen = 0; done_cnt = 0; err_seen = 0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (dup_req && t == 60) begin
        addr = 24'h000000; req = 1'b1;   // R10: must be ignored
      end else req = 1'b0;
    end
    chk(done_cnt == 1, {tag, " R9 done seen"}, done_cnt, 1);
    chk(err_seen == int'(exp_err), {tag, " R1 err flag"}, err_seen, exp_err);
    chk(exp_q.size() == 0, {tag, " R6 all steps issued"}, exp_q.size(), 0);
    if (erases_seen > 0) chk(polls == bp + 1, {tag, " R5 final polls"}, polls, bp + 1);
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !s_start, "reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run("aligned16",  0,          16*256, 256, 8, 0, 0, -1, 0, 0);
    run("odd264",     3*264,      10*264, 264, 9, 3, 2, -1, 0, 0);
    run("short7",     8*256,      7*256,  256, 8, 2, 1, -1, 0, 0);
    run("high",       8184*1024,  8*1024, 1024, 11, 0, 1, -1, 0, 0);
    run("badaddr",    100,        4*256,  256, 8, 0, 0, -1, 1, 0);
    run("badlen",     0,          300,    256, 8, 0, 0, -1, 1, 0);
    run("zerops",     0,          256,    0,   8, 0, 0, -1, 1, 0);
    run("zerolen R9", 4*256,      0,      256, 8, 0, 0, -1, 0, 0);
    run("retry R7",   0,          9*256,  256, 8, 1, 1, 0, 0, 0);
    run("busyreq R10",5*512,      4*512,  512, 9, 1, 3, -1, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule